// File: doc/BRIEF.md
# Prioritized Pending-Interrupt Arbiter

This block keeps one pending flag per interrupt source and, whenever the processor signals that it can accept an interrupt, picks the single most urgent source whose enable conditions currently hold. Each source has a set input and a clear input. The set input raises the flag. The clear input lets a source that drives a level withdraw its request. The arbiter reports the chosen source as a 5-bit exception code together with a one-cycle take strobe. In the same clock edge it retires the flag of the taken source, unless that source is level-sensitive.

Sources are ranked in a fixed order and arranged in groups. Each group is gated by its own part of the processor state: machine-check enable, critical enable, external enable, and a hypervisor-decrementer condition built from a control bit and the hypervisor, problem-state and external-enable flags. Vector lookup, state saving and handler entry belong to the surrounding pipeline.

Top module: `irq_arb_top`

## Requirements
- R1: After reset every pending flag is 0, takeValid is 0 and takeCode is 0.
- R2: A high setReq[i] makes pending bit i read 1 after the next clock edge. A high clrReq[i] makes it read 0, unless setReq[i] is also high in that cycle, in which case the set wins.
- R3: Pending bit index equals priority rank, with 0 the most urgent. The order is 0 reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable timer, 9 decrementer, 10 external input, 11 doorbell, 12 performance monitor, 13 thermal. When several eligible sources are pending, only the lowest index is taken.
- R4: Machine check (bit 1) is eligible only while meEn is 1.
- R5: The hypervisor decrementer (bit 3) is eligible only while hdecEn is 1 and at least one of the following holds: eeEn is 1, hvMode is 0, or prMode is 1.
- R6: Bits 4, 5 and 6 are eligible only while ceEn is 1.
- R7: Bits 7 to 13 are eligible only while eeEn is 1. Reset (bit 0) and debug (bit 2) are always eligible.
- R8: A take happens only at a clock edge where ready is 1 and some pending source is eligible. takeValid is then 1 for exactly the following cycle. When ready is 0, no take occurs and no pending flag is consumed.
- R9: A taken source has its pending bit cleared at the take edge. The exceptions are bit 4 (critical external) and bit 10 (external input): these stay pending until clrReq is used.
- R10: takeCode equals the taken bit index plus 1 (values 1 to 14) while takeValid is 1, and 0 otherwise.
- R11: If no pending source is eligible, nothing is taken and the pending flags are unchanged apart from set and clear inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setReq | input | 14 | Per-source request set |
| clrReq | input | 14 | Per-source request withdraw |
| meEn | input | 1 | Machine-check enable |
| ceEn | input | 1 | Critical enable |
| eeEn | input | 1 | External enable |
| hvMode | input | 1 | Hypervisor state |
| prMode | input | 1 | Problem (user) state |
| hdecEn | input | 1 | Hypervisor-decrementer control enable bit |
| ready | input | 1 | Processor can accept an interrupt this cycle |
| takeValid | output | 1 | One-cycle take strobe |
| takeCode | output | 5 | Exception code of the taken source |
| pendingOut | output | 14 | Current pending flags |

## Verification
All three outputs are registered. Each one shows the effect of the inputs applied in one cycle after exactly one rising edge: the take strobe, the code and the updated pending flags all become visible together. The bench applies each stimulus on a falling edge. It then waits for the following rising edge and the falling edge after it, and only at that point compares takeValid, takeCode and pendingOut against a reference model. Before the next stimulus it advances the model by that one cycle, so every expected value refers to the edge that produced it.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_SRC = 14;
  localparam int CODE_W  = 5;

  localparam int SRC_RESET = 0;
  localparam int SRC_MCHK  = 1;
  localparam int SRC_DEBUG = 2;
  localparam int SRC_HDEC  = 3;
  localparam int SRC_CEXT  = 4;
  localparam int SRC_EXT   = 10;

  // Groups gated by critical enable and external enable
  localparam logic [NUM_SRC-1:0] CRIT_MASK  = NUM_SRC'(14'b00_0000_0111_0000);
  localparam logic [NUM_SRC-1:0] EXT_MASK   = NUM_SRC'(14'b11_1111_1000_0000);
  // Level-type sources that survive being taken
  localparam logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'((1 << SRC_CEXT) | (1 << SRC_EXT));

  // Code table: code = priority rank + 1, 0 means nothing taken
  //  1 reset  2 mcheck  3 debug  4 hdec  5 crit-ext  6 watchdog  7 crit-doorbell
  //  8 fit    9 pit    10 dec   11 ext  12 doorbell 13 perfmon  14 thermal
  localparam logic [CODE_W-1:0] CODE_NONE = '0;

  typedef struct packed {
    logic               fire;
    logic [NUM_SRC-1:0] grant;
  } arbStrobe_t;
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendQ,
  input  logic               meEn,
  input  logic               ceEn,
  input  logic               eeEn,
  input  logic               hvMode,
  input  logic               prMode,
  input  logic               hdecEn,
  input  logic               ready,
  output arbStrobe_t         strobe
);
  logic               hdecOk;
  logic [NUM_SRC-1:0] gateVec;
  logic [NUM_SRC-1:0] eligVec;
  logic [NUM_SRC:0]   blocked;
  logic [NUM_SRC-1:0] grantVec;

  assign hdecOk = hdecEn & (eeEn | ~hvMode | prMode);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
    if (i == SRC_MCHK) begin : g_mchk
      assign gateVec[i] = meEn;
    end else if (i == SRC_HDEC) begin : g_hdec
      assign gateVec[i] = hdecOk;
    end else if (CRIT_MASK[i]) begin : g_crit
      assign gateVec[i] = ceEn;
    end else if (EXT_MASK[i]) begin : g_ext
      assign gateVec[i] = eeEn;
    end else begin : g_free
      assign gateVec[i] = 1'b1;
    end
  end

  assign eligVec    = pendQ & gateVec;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign blocked[i+1] = blocked[i] | eligVec[i];
    assign grantVec[i]  = ready & eligVec[i] & ~blocked[i];
  end

  assign strobe.fire  = ready & blocked[NUM_SRC];
  assign strobe.grant = grantVec;

  p_single_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.grant));
  p_grant_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.grant & ~pendQ) == '0);
  p_mchk_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grant[SRC_MCHK] |-> meEn);
  p_hdec_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grant[SRC_HDEC] |-> (hdecEn && (eeEn || !hvMode || prMode)));
  p_crit_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.grant & CRIT_MASK) != '0) |-> ceEn);
  p_ext_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.grant & EXT_MASK) != '0) |-> eeEn);
  p_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> ready);
endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] setReq,
  input  logic [NUM_SRC-1:0] clrReq,
  input  arbStrobe_t         strobe,
  output logic [NUM_SRC-1:0] pendQ,
  output logic               takeValid,
  output logic [CODE_W-1:0]  takeCode
);
  logic [CODE_W-1:0]  codeNext;
  logic [NUM_SRC-1:0] grantQ;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    logic consume;
    assign consume = strobe.grant[i] & ~LEVEL_MASK[i];
    always_ff @(posedge clk) begin
      if (!rstN) pendQ[i] <= 1'b0;
      else       pendQ[i] <= setReq[i] | (pendQ[i] & ~clrReq[i] & ~consume);
    end
  end

  always_comb begin
    codeNext = CODE_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strobe.grant[i]) codeNext = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeValid <= 1'b0;
      takeCode  <= CODE_NONE;
      grantQ    <= '0;
    end else begin
      takeValid <= strobe.fire;
      takeCode  <= codeNext;
      grantQ    <= strobe.grant;
    end
  end

  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & $past(setReq)) == $past(setReq)));
  p_clear_taken_r9: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> ((grantQ & ~LEVEL_MASK & ~$past(setReq) & pendQ) == '0));
  p_level_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> ((grantQ & LEVEL_MASK & ~$past(clrReq) & ~pendQ) == '0));
  p_code_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    takeValid == (takeCode != CODE_NONE));
  p_one_take_r8: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> $onehot(grantQ));
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] setReq,
  input  logic [NUM_SRC-1:0] clrReq,
  input  logic               meEn,
  input  logic               ceEn,
  input  logic               eeEn,
  input  logic               hvMode,
  input  logic               prMode,
  input  logic               hdecEn,
  input  logic               ready,
  output logic               takeValid,
  output logic [CODE_W-1:0]  takeCode,
  output logic [NUM_SRC-1:0] pendingOut
);
  arbStrobe_t         strobe;
  logic [NUM_SRC-1:0] pendQ;

  irq_arb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pendQ(pendQ),
    .meEn(meEn), .ceEn(ceEn), .eeEn(eeEn),
    .hvMode(hvMode), .prMode(prMode), .hdecEn(hdecEn),
    .ready(ready), .strobe(strobe)
  );

  irq_arb_datapath dp_i (
    .clk(clk), .rstN(rstN), .setReq(setReq), .clrReq(clrReq),
    .strobe(strobe), .pendQ(pendQ),
    .takeValid(takeValid), .takeCode(takeCode)
  );

  assign pendingOut = pendQ;
endmodule

// File: tb/irq_arb_top_tb_top.sv
`timescale 1ns/1ps
module irq_arb_top_tb_top;
  localparam int N = 14;
  localparam logic [N-1:0] LVL = 14'h0410; // bits 4 and 10 (R9)

  logic clk = 1'b0;
  logic rstN;
  logic [N-1:0] setReq, clrReq;
  logic meEn, ceEn, eeEn, hvMode, prMode, hdecEn, ready;
  logic takeValid;
  logic [4:0] takeCode;
  logic [N-1:0] pendingOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [N-1:0] mPend;

  always #2.5 clk = ~clk;

  irq_arb_top dut_i (
    .clk(clk), .rstN(rstN), .setReq(setReq), .clrReq(clrReq),
    .meEn(meEn), .ceEn(ceEn), .eeEn(eeEn), .hvMode(hvMode),
    .prMode(prMode), .hdecEn(hdecEn), .ready(ready),
    .takeValid(takeValid), .takeCode(takeCode), .pendingOut(pendingOut)
  );

  function automatic bit gateOk(int i);
    if (i == 1) return meEn;                                          // R4
    if (i == 3) return hdecEn && (eeEn || !hvMode || prMode);         // R5
    if (i >= 4 && i <= 6) return ceEn;                                // R6
    if (i >= 7) return eeEn;                                          // R7
    return 1'b1;
  endfunction

  function automatic int pick(logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i] && gateOk(i)) return i;    // R3
    return -1;
  endfunction

  task automatic check(string tag, bit ok, string act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [N-1:0] s, logic [N-1:0] c, bit r, string tag);
    int idx;
    bit expTake;
    logic [4:0] expCode;
    logic [N-1:0] clrMask, expPend;
    setReq = s; clrReq = c; ready = r;
    idx = pick(mPend);
    expTake = r && (idx >= 0);
    expCode = expTake ? 5'(idx + 1) : 5'd0;
    clrMask = (expTake && !LVL[idx]) ? (N'(1) << idx) : '0;
    expPend = (mPend & ~c & ~clrMask) | s;
    @(posedge clk);
    @(negedge clk);
    check(tag, takeValid == expTake && takeCode == expCode && pendingOut == expPend,
          $sformatf("v=%0b code=%0d pend=%h", takeValid, takeCode, pendingOut),
          $sformatf("v=%0b code=%0d pend=%h", expTake, expCode, expPend));
    mPend = expPend;
    setReq = '0; clrReq = '0;
  endtask

  task automatic en(bit me, bit ce, bit ee, bit hv, bit pr, bit hd);
    meEn = me; ceEn = ce; eeEn = ee; hvMode = hv; prMode = pr; hdecEn = hd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; setReq = '0; clrReq = '0; ready = 1'b0;
    en(0, 0, 0, 0, 0, 0);
    mPend = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1", pendingOut == '0 && takeValid == 0 && takeCode == 0,
          $sformatf("pend=%h v=%0b code=%0d", pendingOut, takeValid, takeCode), "pend=0 v=0 code=0");

    // R2 / R8: set with ready low, nothing taken
    en(1, 1, 1, 1, 0, 1);
    cyc(14'h0003, '0, 1'b0, "R2");
    cyc('0, '0, 1'b0, "R8");
    // R3 / R10: reset before machine check
    cyc('0, '0, 1'b1, "R3");
    cyc('0, '0, 1'b1, "R10");
    cyc('0, '0, 1'b1, "R11");
    // R4: machine check gated
    en(0, 1, 1, 1, 0, 1);
    cyc(14'h0002, '0, 1'b1, "R4");
    cyc('0, '0, 1'b1, "R4");
    en(1, 1, 1, 1, 0, 1);
    cyc('0, '0, 1'b1, "R4");
    // R5: hypervisor decrementer combinations
    en(1, 1, 1, 0, 0, 0);
    cyc(14'h0008, '0, 1'b1, "R5");
    cyc('0, '0, 1'b1, "R5");
    en(1, 1, 0, 1, 0, 1);
    cyc('0, '0, 1'b1, "R5");
    en(1, 1, 0, 1, 1, 1);
    cyc('0, '0, 1'b1, "R5");
    // R6 / R7: watchdog gated by ceEn, timer taken instead
    en(1, 0, 1, 0, 0, 0);
    cyc(14'h00A0, '0, 1'b1, "R6");
    cyc('0, '0, 1'b1, "R6");
    en(1, 1, 1, 0, 0, 0);
    cyc('0, '0, 1'b1, "R6");
    // R7: external group off, debug still taken
    en(1, 1, 0, 0, 0, 0);
    cyc(14'h2004, '0, 1'b1, "R7");
    cyc('0, '0, 1'b1, "R7");
    en(1, 1, 1, 0, 0, 0);
    cyc('0, '0, 1'b1, "R7");
    // R9: level external input stays pending
    cyc(14'h0400, '0, 1'b1, "R9");
    cyc('0, '0, 1'b1, "R9");
    cyc('0, '0, 1'b1, "R9");
    cyc('0, 14'h0400, 1'b0, "R9");
    cyc(14'h0010, '0, 1'b1, "R9");
    cyc('0, '0, 1'b1, "R9");
    cyc('0, 14'h0010, 1'b0, "R9");
    // R2: set beats clear in same cycle
    cyc(14'h0800, 14'h0800, 1'b0, "R2");
    cyc('0, 14'h0800, 1'b0, "R2");
    // R8: ready low leaves pending alone
    cyc(14'h1000, '0, 1'b0, "R8");
    cyc('0, '0, 1'b0, "R8");
    cyc('0, '0, 1'b1, "R8");

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] s, c;
      if (k % 8 == 0) begin
        logic [5:0] e;
        e = 6'($urandom);
        en(e[0], e[1], e[2], e[3], e[4], e[5]);
      end
      s = N'($urandom & $urandom & $urandom);
      c = N'($urandom & $urandom);
      cyc(s, c, ($urandom % 4) != 0, "R3");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule